// File: doc/BRIEF.md
# Low-Frequency Down-Counting Tick Timer

This block is a periodic/one-shot tick source. A 28-bit counter counts down once for every rising edge of a slow 32768 Hz reference, which gives a resolution of about 30.5 us. Software reaches it through a small register interface on the fast bus clock. That interface has three registers: control, preload and a read-only count.

All state lives on the bus clock. The slow reference is sampled by a synchronizer, and each of its rising edges becomes a one-cycle advance strobe. As a result, a control write takes effect at the next slow edge, which is anywhere from a few bus cycles to one full slow period later. A rising edge of the run bit clears the count at once and arms a pending load. The count then reads zero while the run bit reads one, until the next slow edge copies the preload value in.

When the count steps from one to zero, the block emits an interrupt pulse one bus cycle long. The following slow edge reloads the preload value. A debug-halt input can freeze the counter, but only when the freeze-enable bit is set.

Top module: `lf_tick_timer`

## Requirements
- R1: While running (enable bit 0 and run bit 1 of control both set, not frozen, no pending load), the count decreases by exactly one at each slow-clock rising edge.
- R2: A control write that takes the enable-and-run combination from false to true clears the count to 0 at once and leaves a pending load. Until the next slow edge, the count reads 0 while control bit 1 reads 1. That slow edge loads the preload value.
- R3: Writing preload while the counter runs leaves the current count unchanged. The new value is first used at the next reload.
- R4: When the count steps from 1 to 0, `irq` is high for exactly one bus cycle. At the next slow edge, the count reloads from preload. A preload of 0 keeps the count at 0 and raises no interrupt.
- R5: With the freeze-enable bit (control bit 2) set and `debug_halt` high, slow edges change neither the count nor a pending load. With bit 2 clear, `debug_halt` has no effect.
- R6: A control write with bit 0 clear stops the timer at once. It clears the count to 0, drops any pending load and suppresses an interrupt due in that cycle. No interrupt follows while the timer is stopped.
- R7: With enable set and run clear, the count holds its value across slow edges.
- R8: Preload and count are 28 bits wide and read with bits 31:28 as zero. Control reads its three bits in positions 2:0, with every other bit zero.
- R9: The register map is: address 0 control, address 1 preload, address 2 count (read-only, writes ignored). Address 3 reads zero.
- R10: After reset, control, preload, count and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state is registered on its rising edge |
| rst_n | input | 1 | Active-low reset |
| lf_clk | input | 1 | 32768 Hz slow reference, asynchronous to clk |
| debug_halt | input | 1 | Debugger halt request |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 28 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
Register writes are due on the next bus edge: the cleared count and the pending load read back right after the write. Effects of the slow clock lag its rising edge by three bus edges, two for the synchronizer and one for the counter, and `irq` rises on that same third edge. The bench drives each slow period as four bus cycles high and four low, so every slow-edge result is complete before the next register access. `irq` is sampled on falling bus edges, so each one-cycle pulse is counted exactly once.

// File: rtl/lft_pkg.sv
package lft_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL    = 2'd0,
    REG_PRELOAD = 2'd1,
    REG_COUNT   = 2'd2,
    REG_NONE    = 2'd3
  } reg_addr_e;

  // bit 2 freeze enable, bit 1 run, bit 0 enable
  typedef struct packed {
    logic freeze_en;
    logic run;
    logic en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic ctrl_active(input ctrl_t c);
    return c.en & c.run;
  endfunction

endpackage

// File: rtl/lft_edge_sync.sv
module lft_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int LAST = STAGES;

  logic [LAST:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[LAST-1:0], async_in};
  end

  assign rise = shift_q[LAST-1] & ~shift_q[LAST];

  AST_STEP_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R1

endmodule

// File: rtl/lft_regs.sv
module lft_regs
  import lft_pkg::*;
#(
  parameter int CNT_W  = 28,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [CNT_W-1:0]      bus_wdata,
  input  logic [CNT_W-1:0]      count_q,
  output logic [DATA_W-1:0]     bus_rdata,
  output ctrl_t                 ctrl_q,
  output logic [CNT_W-1:0]      preload_q,
  output logic                  stop_wr,
  output logic                  start_rise
);
  ctrl_t ctrl_new;
  logic  ctrl_wr;
  logic  preload_wr;

  assign ctrl_new   = ctrl_t'(bus_wdata[CTRL_W-1:0]);
  assign ctrl_wr    = bus_wr && (bus_addr == REG_CTRL);
  assign preload_wr = bus_wr && (bus_addr == REG_PRELOAD);
  assign stop_wr    = ctrl_wr && !ctrl_new.en;
  assign start_rise = ctrl_wr && ctrl_active(ctrl_new) && !ctrl_active(ctrl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      preload_q <= '0;
    end else begin
      if (ctrl_wr)    ctrl_q    <= ctrl_new;
      if (preload_wr) preload_q <= bus_wdata;
    end
  end

  always_comb begin
    unique case (bus_addr)
      REG_CTRL:    bus_rdata = DATA_W'(ctrl_q);
      REG_PRELOAD: bus_rdata = DATA_W'(preload_q);
      REG_COUNT:   bus_rdata = DATA_W'(count_q);
      default:     bus_rdata = '0;
    endcase
  end

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:CNT_W] == '0); // R8

  AST_PRELOAD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !preload_wr |=> $stable(preload_q)); // R3

endmodule

// File: rtl/lft_core.sv
module lft_core
  import lft_pkg::*;
#(
  parameter int CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lf_step,
  input  logic             debug_halt,
  input  ctrl_t            ctrl_q,
  input  logic [CNT_W-1:0] preload_q,
  input  logic             stop_wr,
  input  logic             start_rise,
  output logic [CNT_W-1:0] count_q,
  output logic             irq_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] next_value(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] reload
  );
    return (cur == '0) ? reload : cur - ONE;
  endfunction

  logic pend_q;
  logic frozen;
  logic advance;
  logic hit;
  logic override;

  assign frozen   = ctrl_q.freeze_en & debug_halt;
  assign advance  = lf_step & ctrl_active(ctrl_q) & ~frozen;
  assign hit      = advance & ~pend_q & (count_q == ONE);
  assign override = stop_wr | start_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      pend_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= hit & ~override;
      if (stop_wr) begin
        count_q <= '0;
        pend_q  <= 1'b0;
      end else if (start_rise) begin
        count_q <= '0;
        pend_q  <= 1'b1;
      end else if (advance) begin
        if (pend_q) begin
          count_q <= preload_q;
          pend_q  <= 1'b0;
        end else begin
          count_q <= next_value(count_q, preload_q);
        end
      end
    end
  end

  AST_STEP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !pend_q && count_q != '0 && !override)
      |=> count_q == $past(count_q) - ONE); // R1

  AST_PEND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> count_q == '0); // R2

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !override && (pend_q || count_q == '0))
      |=> count_q == $past(preload_q)); // R4

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R4

  AST_IRQ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> count_q == '0); // R4

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lf_step && frozen && !override) |=> ($stable(count_q) && $stable(pend_q))); // R5

  AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> (count_q == '0 && !pend_q && !irq_q)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !override) |=> $stable(count_q)); // R7

endmodule

// File: rtl/lf_tick_timer.sv
module lf_tick_timer
  import lft_pkg::*;
#(
  parameter int CNT_W       = 28,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lf_clk,
  input  logic              debug_halt,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic             lf_step;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] preload_q;
  logic [CNT_W-1:0] count_q;
  logic             stop_wr;
  logic             start_rise;

  lft_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (lf_clk),
    .rise     (lf_step)
  );

  lft_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .count_q    (count_q),
    .bus_rdata  (bus_rdata),
    .ctrl_q     (ctrl_q),
    .preload_q  (preload_q),
    .stop_wr    (stop_wr),
    .start_rise (start_rise)
  );

  lft_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .lf_step    (lf_step),
    .debug_halt (debug_halt),
    .ctrl_q     (ctrl_q),
    .preload_q  (preload_q),
    .stop_wr    (stop_wr),
    .start_rise (start_rise),
    .count_q    (count_q),
    .irq_q      (irq)
  );

endmodule

// File: tb/lf_tick_timer_test.sv
module lf_tick_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lf_clk = 1'b0;
  logic        debug_halt = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [27:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  int irq_seen = 0;

  always #5 clk = ~clk;

  lf_tick_timer uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .lf_clk     (lf_clk),
    .debug_halt (debug_halt),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq        (irq)
  );

  always @(negedge clk) if (irq) irq_seen <= irq_seen + 1;

  typedef struct packed {
    logic [27:0] preload;
    logic [7:0]  ticks;
    logic [27:0] exp_count;
    logic [7:0]  exp_irqs;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{28'd5,         8'd3, 28'd3,         8'd0},
    '{28'd3,         8'd5, 28'd3,         8'd1},
    '{28'd2,         8'd8, 28'd1,         8'd2},
    '{28'd0,         8'd4, 28'd0,         8'd0},
    '{28'd1,         8'd6, 28'd0,         8'd3},
    '{28'h0FFFFFFF,  8'd2, 28'h0FFFFFFE,  8'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [27:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic slow_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); lf_clk = 1'b1;
      repeat (4) @(negedge clk);
      lf_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd(2'd0, v); check("R10 ctrl", v, 0);
    rd(2'd1, v); check("R10 preload", v, 0);
    rd(2'd2, v); check("R10 count", v, 0);
    check("R10 irq", {31'd0, irq}, 0);

    // R1 R4 table of preload/tick patterns
    for (int r = 0; r < 6; r++) begin
      wr(2'd0, 28'd0);
      wr(2'd1, VEC[r].preload);
      base = irq_seen;
      wr(2'd0, 28'd3);
      if (r == 0) begin
        rd(2'd2, v); check("R2 pending count", v, 0);
        rd(2'd0, v); check("R2 run bit reads 1", {31'd0, v[1]}, 1);
      end
      slow_ticks(VEC[r].ticks);
      rd(2'd2, v); check("R1 count", v, {4'd0, VEC[r].exp_count});
      check("R4 irq pulses", irq_seen - base, {24'd0, VEC[r].exp_irqs});
    end

    // R3 preload rewrite while running; R9 count write ignored
    wr(2'd0, 28'd0);
    wr(2'd1, 28'd4);
    wr(2'd0, 28'd3);
    slow_ticks(2);
    wr(2'd1, 28'd9);
    wr(2'd2, 28'd123);
    rd(2'd2, v); check("R3 count unchanged by preload write", v, 3);
    check("R9 count write ignored", v, 3);
    rd(2'd3, v); check("R9 unused address reads zero", v, 0);
    slow_ticks(4);
    rd(2'd2, v); check("R3 new preload used at reload", v, 9);

    // R5 freeze with halt enabled
    wr(2'd0, 28'd0);
    wr(2'd1, 28'd6);
    wr(2'd0, 28'd7);
    debug_halt = 1'b1;
    slow_ticks(2);
    rd(2'd2, v); check("R5 pending load frozen", v, 0);
    debug_halt = 1'b0;
    slow_ticks(2);
    rd(2'd2, v); check("R5 runs after release", v, 5);
    debug_halt = 1'b1;
    slow_ticks(2);
    rd(2'd2, v); check("R5 count frozen", v, 5);
    wr(2'd0, 28'd3);
    slow_ticks(1);
    rd(2'd2, v); check("R5 halt ignored when disabled", v, 4);
    debug_halt = 1'b0;

    // R7 hold with run clear
    wr(2'd0, 28'd1);
    slow_ticks(2);
    rd(2'd2, v); check("R7 hold", v, 4);

    // R6 stop
    wr(2'd0, 28'd3);
    wr(2'd0, 28'd0);
    rd(2'd2, v); check("R6 stop clears count", v, 0);
    base = irq_seen;
    slow_ticks(3);
    rd(2'd2, v); check("R6 stays stopped", v, 0);
    check("R6 no irq while stopped", irq_seen - base, 0);
    wr(2'd1, 28'd2);
    wr(2'd0, 28'd2);
    slow_ticks(2);
    rd(2'd2, v); check("R6 run without enable does not load", v, 0);

    // R8 widths and control readback
    wr(2'd1, 28'hFFFFFFF);
    rd(2'd1, v); check("R8 preload width", v, 32'h0FFFFFFF);
    wr(2'd0, 28'hFFFFFFF);
    rd(2'd0, v); check("R8 control bits", v, 32'h7);
    wr(2'd0, 28'd0);

    finish_run();
  end

endmodule